// File: doc/BRIEF.md
# Segmented Address Translator with Bound Protection

This block turns an effective address into a physical address through a small table of segments. Each segment is a base address, an exclusive upper bound and a valid flag. A request picks one entry. The block adds that entry's base to the in-segment offset, then compares the sum against the entry's bound. One cycle later it returns the physical address and a violation flag.

Privileged software loads the table through a write port. Typically it reloads the table with the next process's segments on a context switch. Writes made without privilege are dropped.

The segment can be chosen in two ways:
- **Explicit:** it is taken from the top bits of the effective address.
- **Implicit:** it is taken from the access kind. An instruction fetch uses a fixed code entry and a data access uses a fixed data entry. The whole effective address then serves as the offset. Used with one entry, this gives plain base-and-bound relocation.

Top module: `seg_xlate`

## Requirements
- R1: In explicit mode (`req_implicit`=0) the segment number is `req_ea[31:29]` and the offset is `req_ea[28:0]`, zero-extended to 32 bits.
- R2: A request presented with `req_valid`=1 produces a response in the following cycle, with `rsp_valid`=1 and `rsp_pa` equal to the selected entry's base plus the offset.
- R3: An access is allowed only when base plus offset, taken as a 33-bit sum, is strictly less than the entry's bound. An access whose sum reaches or exceeds the bound, including one with a carry out of bit 31, gives `rsp_fault`=1.
- R4: Reset clears every entry to invalid. A request that selects an invalid entry gives `rsp_fault`=1.
- R5: When `rsp_fault`=1 the value of `rsp_pa` is 0. In a cycle with no response, `rsp_valid`, `rsp_fault` and `rsp_pa` are all 0.
- R6: A table write takes effect only when `cfg_we` and `cfg_priv` are both 1. A write with `cfg_priv`=0 leaves the table unchanged.
- R7: In implicit mode (`req_implicit`=1) the block uses entry 0 for an instruction fetch (`req_is_fetch`=1) and entry 1 for a data access. In this mode the offset is the full 32-bit `req_ea`.
- R8: A request made in the same cycle as a write to its entry is translated with the entry's contents from before that write. The next request sees the new contents.
- R9: After an entry is rewritten, translations through that entry use only the new base, bound and valid values. This lets a table reload replace one process's segments with another's.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_priv | input | 1 | Writer is privileged; a write without it is dropped |
| cfg_idx | input | 3 | Entry to write |
| cfg_valid | input | 1 | Valid flag for the written entry |
| cfg_base | input | 32 | Base address for the written entry |
| cfg_bound | input | 32 | Exclusive upper bound for the written entry |
| req_valid | input | 1 | Translation request present |
| req_ea | input | 32 | Effective address |
| req_is_fetch | input | 1 | 1 for an instruction fetch, 0 for a data access |
| req_implicit | input | 1 | 1 selects the segment from the access kind |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_pa | output | 32 | Physical address; 0 on a violation |
| rsp_fault | output | 1 | Violation: invalid entry or address not below the bound |

## Verification
The assertions assume three things about the inputs:
- `req_valid` is 0 while reset is held.
- The table is written only through a strobe that is qualified by privilege.
- Every response that appears before any privileged write refers to the table state left by reset.

The stimulus meets these assumptions as follows. It holds all inputs at 0 through reset. It issues a request against the empty table before any load. It changes the request and configuration inputs only on falling edges, so each response is tied to exactly one earlier request.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
    typedef enum logic [0:0] {
        ACC_DATA  = 1'b0,
        ACC_FETCH = 1'b1
    } acc_kind_e;

    typedef enum logic [0:0] {
        SEL_EXPLICIT = 1'b0,
        SEL_IMPLICIT = 1'b1
    } sel_mode_e;
endpackage

// File: rtl/seg_table.sv
module seg_table #(
    parameter int SEG_W = 3,
    parameter int PA_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_priv,
    input  logic [SEG_W-1:0] wr_idx,
    input  logic             wr_vld,
    input  logic [PA_W-1:0]  wr_base,
    input  logic [PA_W-1:0]  wr_bnd,
    input  logic [SEG_W-1:0] rd_idx,
    output logic             rd_vld,
    output logic [PA_W-1:0]  rd_base,
    output logic [PA_W-1:0]  rd_bnd
);
    localparam int NUM_SEG = 1 << SEG_W;

    typedef struct packed {
        logic            vld;
        logic [PA_W-1:0] base;
        logic [PA_W-1:0] bnd;
    } ent_t;

    ent_t [NUM_SEG-1:0] tbl_d, tbl_q;
    logic               wr_ok;

    assign wr_ok = wr_en & wr_priv;

    for (genvar gi = 0; gi < NUM_SEG; gi++) begin : g_ent
        always_comb begin
            tbl_d[gi] = tbl_q[gi];
            if (wr_ok && (wr_idx == SEG_W'(gi))) begin
                tbl_d[gi].vld  = wr_vld;
                tbl_d[gi].base = wr_base;
                tbl_d[gi].bnd  = wr_bnd;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign rd_vld  = tbl_q[rd_idx].vld;
    assign rd_base = tbl_q[rd_idx].base;
    assign rd_bnd  = tbl_q[rd_idx].bnd;
endmodule

// File: rtl/seg_select.sv
module seg_select
    import seg_xlate_pkg::*;
#(
    parameter int EA_W     = 32,
    parameter int SEG_W    = 3,
    parameter int CODE_IDX = 0,
    parameter int DATA_IDX = 1
) (
    input  logic [EA_W-1:0]  ea,
    input  acc_kind_e        kind,
    input  sel_mode_e        mode,
    output logic [SEG_W-1:0] idx,
    output logic [EA_W-1:0]  off
);
    localparam int OFF_W = EA_W - SEG_W;

    always_comb begin
        if (mode == SEL_IMPLICIT) begin
            idx = (kind == ACC_FETCH) ? SEG_W'(CODE_IDX) : SEG_W'(DATA_IDX);
            off = ea;
        end else begin
            idx = ea[EA_W-1:OFF_W];
            off = {{SEG_W{1'b0}}, ea[OFF_W-1:0]};
        end
    end
endmodule

// File: rtl/seg_check.sv
module seg_check #(
    parameter int EA_W = 32,
    parameter int PA_W = 32
) (
    input  logic            vld,
    input  logic [PA_W-1:0] base,
    input  logic [PA_W-1:0] bnd,
    input  logic [EA_W-1:0] off,
    output logic [PA_W-1:0] pa,
    output logic            fault
);
    localparam int SUM_W = ((PA_W > EA_W) ? PA_W : EA_W) + 1;

    logic [SUM_W-1:0] sum_w;
    logic [SUM_W-1:0] bnd_w;
    logic             ok;

    always_comb begin
        sum_w = SUM_W'(base) + SUM_W'(off);
        bnd_w = SUM_W'(bnd);
        ok    = vld && (sum_w < bnd_w);
        fault = !ok;
        pa    = ok ? sum_w[PA_W-1:0] : '0;
    end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int EA_W     = 32,
    parameter int PA_W     = 32,
    parameter int SEG_W    = 3,
    parameter int CODE_IDX = 0,
    parameter int DATA_IDX = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_priv,
    input  logic [SEG_W-1:0] cfg_idx,
    input  logic             cfg_valid,
    input  logic [PA_W-1:0]  cfg_base,
    input  logic [PA_W-1:0]  cfg_bound,
    input  logic             req_valid,
    input  logic [EA_W-1:0]  req_ea,
    input  logic             req_is_fetch,
    input  logic             req_implicit,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_pa,
    output logic             rsp_fault
);
    typedef struct packed {
        logic            vld;
        logic [PA_W-1:0] pa;
        logic            flt;
    } rsp_t;

    rsp_t             rsp_d, rsp_q;
    logic [SEG_W-1:0] sel_idx;
    logic [EA_W-1:0]  sel_off;
    logic             ent_vld;
    logic [PA_W-1:0]  ent_base, ent_bnd;
    logic [PA_W-1:0]  chk_pa;
    logic             chk_fault;
    acc_kind_e        kind;
    sel_mode_e        mode;

    assign kind = req_is_fetch ? ACC_FETCH : ACC_DATA;
    assign mode = req_implicit ? SEL_IMPLICIT : SEL_EXPLICIT;

    seg_select #(
        .EA_W(EA_W), .SEG_W(SEG_W), .CODE_IDX(CODE_IDX), .DATA_IDX(DATA_IDX)
    ) u_select (
        .ea(req_ea), .kind(kind), .mode(mode), .idx(sel_idx), .off(sel_off)
    );

    seg_table #(.SEG_W(SEG_W), .PA_W(PA_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we), .wr_priv(cfg_priv), .wr_idx(cfg_idx),
        .wr_vld(cfg_valid), .wr_base(cfg_base), .wr_bnd(cfg_bound),
        .rd_idx(sel_idx), .rd_vld(ent_vld), .rd_base(ent_base), .rd_bnd(ent_bnd)
    );

    seg_check #(.EA_W(EA_W), .PA_W(PA_W)) u_check (
        .vld(ent_vld), .base(ent_base), .bnd(ent_bnd), .off(sel_off),
        .pa(chk_pa), .fault(chk_fault)
    );

    always_comb begin
        rsp_d     = '0;
        rsp_d.vld = req_valid;
        if (req_valid) begin
            rsp_d.pa  = chk_pa;
            rsp_d.flt = chk_fault;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.vld;
    assign rsp_pa    = rsp_q.pa;
    assign rsp_fault = rsp_q.flt;
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
    parameter int PA_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_we,
    input logic            cfg_priv,
    input logic            req_valid,
    input logic            rsp_valid,
    input logic [PA_W-1:0] rsp_pa,
    input logic            rsp_fault
);
    logic wr_seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_seen_q <= 1'b0;
        end else if (cfg_we && cfg_priv) begin
            wr_seen_q <= 1'b1;
        end
    end

    p_rsp_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_no_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_fault_pa_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_pa == '0));

    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_fault && rsp_pa == '0));

    p_empty_faults_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !wr_seen_q) |-> rsp_fault);
endmodule

bind seg_xlate seg_xlate_chk #(.PA_W(PA_W)) u_seg_xlate_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_priv(cfg_priv),
    .req_valid(req_valid), .rsp_valid(rsp_valid), .rsp_pa(rsp_pa),
    .rsp_fault(rsp_fault)
);

// File: tb/seg_xlate_bench.sv
module seg_xlate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_priv = 1'b0, cfg_valid = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [31:0] cfg_base = '0, cfg_bound = '0;
    logic        req_valid = 1'b0, req_is_fetch = 1'b0, req_implicit = 1'b0;
    logic [31:0] req_ea = '0;
    logic        rsp_valid, rsp_fault;
    logic [31:0] rsp_pa;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic        m_vld  [8];
    logic [31:0] m_base [8];
    logic [31:0] m_bnd  [8];

    always #10 clk = ~clk;

    seg_xlate u_seg_xlate (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_priv(cfg_priv), .cfg_idx(cfg_idx),
        .cfg_valid(cfg_valid), .cfg_base(cfg_base), .cfg_bound(cfg_bound),
        .req_valid(req_valid), .req_ea(req_ea), .req_is_fetch(req_is_fetch),
        .req_implicit(req_implicit),
        .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault)
    );

    task automatic check3(string tag, logic v, logic [31:0] pa, logic f,
                          logic ev, logic [31:0] epa, logic ef);
        checks++;
        if (v !== ev || pa !== epa || f !== ef) begin
            failures++;
            $display("FAIL %s: got valid=%0b pa=%h fault=%0b, expected valid=%0b pa=%h fault=%0b",
                     tag, v, pa, f, ev, epa, ef);
        end
    endtask

    task automatic wr(logic [2:0] idx, logic vld, logic [31:0] base,
                      logic [31:0] bnd, logic priv);
        @(negedge clk);
        cfg_we = 1'b1; cfg_priv = priv; cfg_idx = idx;
        cfg_valid = vld; cfg_base = base; cfg_bound = bnd;
        @(negedge clk);
        cfg_we = 1'b0; cfg_priv = 1'b0;
        if (priv) begin
            m_vld[idx] = vld; m_base[idx] = base; m_bnd[idx] = bnd;
        end
    endtask

    function automatic void expect_of(logic [31:0] ea, logic fetch, logic impl,
                                      output logic [31:0] epa, output logic ef);
        logic [2:0]  idx;
        logic [32:0] sum;
        logic [31:0] off;
        if (impl) begin
            idx = fetch ? 3'd0 : 3'd1;
            off = ea;
        end else begin
            idx = ea[31:29];
            off = {3'b000, ea[28:0]};
        end
        sum = {1'b0, m_base[idx]} + {1'b0, off};
        ef  = !(m_vld[idx] && (sum < {1'b0, m_bnd[idx]}));
        epa = ef ? 32'h0 : sum[31:0];
    endfunction

    task automatic req(string tag, logic [31:0] ea, logic fetch, logic impl);
        logic [31:0] epa;
        logic        ef;
        expect_of(ea, fetch, impl, epa, ef);
        @(negedge clk);
        req_valid = 1'b1; req_ea = ea; req_is_fetch = fetch; req_implicit = impl;
        @(negedge clk);
        req_valid = 1'b0;
        check3(tag, rsp_valid, rsp_pa, rsp_fault, 1'b1, epa, ef);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            m_vld[i] = 1'b0; m_base[i] = '0; m_bnd[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R5: quiet after reset
        check3("R5 reset", rsp_valid, rsp_pa, rsp_fault, 1'b0, 32'h0, 1'b0);
        // R4: empty table faults
        req("R4 empty table", 32'h4000_0010, 1'b0, 1'b0);
        // R6: unprivileged write dropped
        wr(3'd2, 1'b1, 32'h0000_1000, 32'hFFFF_0000, 1'b0);
        req("R6 unpriv write ignored", 32'h4000_0010, 1'b0, 1'b0);
        // load table, entry 5 left invalid
        for (int i = 0; i < 8; i++) begin
            wr(3'(i), (i != 5), (32'(i) << 28) | 32'h100,
               ((32'(i) << 28) | 32'h100) + 32'h0001_0000 + 32'(i) * 32'h0040_0000, 1'b1);
        end
        // R1 R2 R3 R4 R5: sweep every segment across the bound edge
        for (int s = 0; s < 8; s++) begin
            logic [31:0] lim;
            lim = m_bnd[s] - m_base[s];
            req("R1/R2/R3 off0", {3'(s), 29'h0}, 1'b0, 1'b0);
            req("R3 below bound", {3'(s), lim[28:0] - 29'd1}, 1'b0, 1'b0);
            req("R3 at bound", {3'(s), lim[28:0]}, 1'b0, 1'b0);
            req("R3 past bound", {3'(s), lim[28:0] + 29'd1}, 1'b0, 1'b0);
            req("R5 max offset", {3'(s), 29'h1FFF_FFFF}, 1'b1, 1'b0);
        end
        // R6: unprivileged write on a loaded entry leaves it unchanged
        wr(3'd2, 1'b0, 32'h0, 32'h0, 1'b0);
        req("R6 unpriv keeps entry", 32'h4000_0020, 1'b0, 1'b0);
        // R3: carry out of bit 31
        wr(3'd6, 1'b1, 32'hF000_0000, 32'hFFFF_FFFF, 1'b1);
        req("R3 in range high", 32'hC000_1000, 1'b0, 1'b0);
        req("R3 carry out", 32'hD000_0000, 1'b0, 1'b0);
        // R7: implicit selection
        wr(3'd0, 1'b1, 32'h0010_0000, 32'h8000_0000, 1'b1);
        wr(3'd1, 1'b1, 32'h4000_0000, 32'hC000_0000, 1'b1);
        req("R7 fetch", 32'h0000_1234, 1'b1, 1'b1);
        req("R7 data", 32'h0000_1234, 1'b0, 1'b1);
        req("R7 fetch top bits", 32'hE000_0010, 1'b1, 1'b1);
        req("R7 data bound", 32'h7FFF_FFFF, 1'b0, 1'b1);
        req("R7 data inside", 32'h7FFF_FFFE, 1'b0, 1'b1);
        req("R7 fetch large", 32'h7FEF_FFFF, 1'b1, 1'b1);
        // R8: request in the same cycle as a write sees old contents
        begin
            logic [31:0] epa;
            logic        ef;
            expect_of(32'h6000_0040, 1'b0, 1'b0, epa, ef);
            @(negedge clk);
            cfg_we = 1'b1; cfg_priv = 1'b1; cfg_idx = 3'd3; cfg_valid = 1'b1;
            cfg_base = 32'h0900_0000; cfg_bound = 32'h0A00_0000;
            req_valid = 1'b1; req_ea = 32'h6000_0040; req_implicit = 1'b0;
            @(negedge clk);
            cfg_we = 1'b0; cfg_priv = 1'b0; req_valid = 1'b0;
            check3("R8 same-cycle old", rsp_valid, rsp_pa, rsp_fault, 1'b1, epa, ef);
            m_vld[3] = 1'b1; m_base[3] = 32'h0900_0000; m_bnd[3] = 32'h0A00_0000;
        end
        // R9: new contents used afterwards
        req("R9 new base", 32'h6000_0040, 1'b0, 1'b0);
        wr(3'd3, 1'b0, 32'h0900_0000, 32'h0A00_0000, 1'b1);
        req("R9 invalidated", 32'h6000_0040, 1'b0, 1'b0);
        // R5 R2: idle cycle after response
        @(negedge clk);
        check3("R5 idle", rsp_valid, rsp_pa, rsp_fault, 1'b0, 32'h0, 1'b0);
        finish_run();
    end
endmodule